// File: doc/BRIEF.md
# Multi-Mode Parallel Converter Strobe Controller

This block sits on the host side of an 8-bit parallel analog-to-digital converter. It generates the chip-select, write, read, mode and power-down strobes, watches the converter's ready and end-of-conversion lines, and captures the data bus. A client asks for a sample with a valid/ready handshake and gets back a one-cycle response that carries the data byte and a flag saying whether that byte is a real sample.

Four strobe protocols are available, chosen per request by `cfg_mode`. The mode is sampled only when a request is accepted. In read-only mode a single read strobe starts the conversion, and the result is taken once the ready line has dropped and come back high. The two write-then-read modes differ in when they issue the read strobe. The first waits for the end-of-conversion line to fall. The second issues the read a fixed delay after the write strobe rises and does not look at the end-of-conversion line at all. In pipelined mode, write and read move together, so each strobe starts a new conversion and collects the result of the one before it. The controller also puts the converter into power-down and brings it back out. It enforces the acquisition gap between conversions and the wake-up gap after power-down. Every analog delay is given in nanoseconds and turned into clock cycles, rounded up.

Top module: `adc_strobe_ctl`

## Requirements
- R1: After reset, `adc_cs_n`, `adc_wr_n`, `adc_rd_n` and `adc_pd_n` are high, `adc_mode` is low, and `rsp_valid` and `err_timeout` are low.
- R2: With `cfg_mode`=0 (read-only), `adc_mode` is low. `adc_cs_n` and `adc_rd_n` fall together and `adc_wr_n` stays high. The response carries the byte on `adc_d` from the cycle after `adc_rdy` rises, provided `adc_rdy` was seen low during that conversion.
- R3: With `cfg_mode`=1 (write, wait, read), `adc_wr_n` is low for exactly ceil(T_WR_NS/CLK_NS) cycles. `adc_rd_n` falls only while `adc_int_n` is low. `adc_rd_n` then stays low for ceil(T_ACC_NS/CLK_NS) cycles, and the byte on the bus at the end of that read is returned.
- R4: With `cfg_mode`=2 (early read), `adc_rd_n` falls exactly ceil(T_RDLY_NS/CLK_NS) cycles after `adc_wr_n` rises, whatever `adc_int_n` does. The byte on the bus at the end of the read is returned.
- R5: With `cfg_mode`=3 (pipelined), `adc_wr_n` and `adc_rd_n` fall and rise on the same edges. The response carries the result of the previous conversion. `rsp_ok` is 0 when no conversion has completed since reset and 1 otherwise.
- R6: A falling `adc_cs_n` comes at least ceil(T_ACQ_NS/CLK_NS) cycles after the previous rising `adc_cs_n`.
- R7: While `pd_req` is high and the controller is idle, `adc_pd_n` is low, `adc_cs_n` stays high for the whole power-down, and `req_ready` is low.
- R8: A falling `adc_cs_n` comes at least ceil(T_WAKE_NS/CLK_NS) cycles after `adc_pd_n` rises.
- R9: If the awaited ready or end-of-conversion event does not come within TMO_CYC cycles, the controller raises `adc_cs_n`, sets `err_timeout` and produces no response. `err_timeout` clears when the next request is accepted.
- R10: `cfg_mode` is sampled only when a request is accepted. Changing it during a conversion leaves `adc_mode` and the strobe sequence of that conversion unchanged.
- R11: `rsp_valid` is a single-cycle pulse, with one pulse for each completed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Protocol: 0 read-only, 1 write/wait/read, 2 early read, 3 pipelined |
| req_valid | input | 1 | Sample request |
| req_ready | output | 1 | Request accepted when both are high |
| pd_req | input | 1 | Power-down request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 8 | Captured sample |
| rsp_ok | output | 1 | Response holds a real sample |
| err_timeout | output | 1 | Last conversion timed out |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_wr_n | output | 1 | Converter write strobe, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_mode | output | 1 | Converter mode pin, high for the write modes |
| adc_pd_n | output | 1 | Converter power-down, active low |
| adc_rdy | input | 1 | Converter ready line |
| adc_int_n | input | 1 | Converter end-of-conversion, active low |
| adc_d | input | 8 | Converter data bus |

## Verification
The bench builds the controller with a 10 ns clock and with delays chosen so that the rounding-up rule shows: 45 ns gives 5 cycles of write, 31 ns gives 4 cycles of read delay, 30 ns gives a 3-cycle read, 60 ns gives 6 cycles of acquisition and 115 ns gives 12 cycles of wake-up. The timeout is 40 cycles. Because the windows are this short, one run covers every protocol twice, a power-down and wake-up, and a timeout followed by its recovery. The bench's converter model finishes a conversion 8 cycles after the write rises. In early-read mode the read strobe therefore lands before the end of conversion, while in the waiting mode it lands after.

// File: rtl/adc_strobe_pkg.sv
package adc_strobe_pkg;

    typedef enum logic [1:0] {
        M_RDONLY   = 2'd0,
        M_WR_INT   = 2'd1,
        M_WR_EARLY = 2'd2,
        M_PIPE     = 2'd3
    } adc_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SLEEP,
        S_RDO,
        S_WRLO,
        S_WRGAP,
        S_INTW,
        S_RDLO
    } seq_st_e;

    // nanoseconds to whole clock cycles, rounded up, never below one
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        int v;
        v = (ns + clk_ns - 1) / clk_ns;
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/adc_gap_tmr.sv
module adc_gap_tmr #(
    parameter int ACQ_CYC  = 16,
    parameter int WAKE_CYC = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ld_acq,
    input  logic ld_wake,
    output logic done
);
    localparam int MAXV = (ACQ_CYC > WAKE_CYC) ? ACQ_CYC : WAKE_CYC;
    localparam int GW   = $clog2(MAXV + 1);

    logic [GW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (ld_wake)
            cnt_d = GW'(WAKE_CYC);
        else if (ld_acq)
            cnt_d = GW'(ACQ_CYC);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/adc_wdog.sv
module adc_wdog #(
    parameter int TMO_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int TW = $clog2(TMO_CYC + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    assign expire = run && (cnt_q == TW'(TMO_CYC - 1));

    always_comb begin
        if (!run || expire) cnt_d = '0;
        else                cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
    import adc_strobe_pkg::*;
#(
    parameter int DW       = 8,
    parameter int WR_CYC   = 25,
    parameter int RDLY_CYC = 25,
    parameter int ACC_CYC  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_mode,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          pd_req,
    input  logic          gap_done,
    input  logic          tmo,
    output logic          ld_acq,
    output logic          ld_wake,
    output logic          wd_run,
    input  logic          adc_rdy,
    input  logic          adc_int_n,
    input  logic [DW-1:0] adc_d,
    output logic          cs_n,
    output logic          wr_n,
    output logic          rd_n,
    output logic          pd_n,
    output logic          mode_pin,
    output adc_mode_e     cur_mode,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_ok,
    output logic          err
);
    localparam int CMAX = (WR_CYC > RDLY_CYC) ?
                          ((WR_CYC > ACC_CYC) ? WR_CYC : ACC_CYC) :
                          ((RDLY_CYC > ACC_CYC) ? RDLY_CYC : ACC_CYC);
    localparam int CW = $clog2(CMAX + 1);

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
        adc_mode_e     mode;
        logic          cs_n;
        logic          wr_n;
        logic          rd_n;
        logic          pd_n;
        logic          seen;
        logic          rsp_v;
        logic          rsp_ok;
        logic          have_prev;
        logic          err;
        logic [DW-1:0] data;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st: S_IDLE, cnt: '0, mode: M_RDONLY,
        cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, pd_n: 1'b1,
        seen: 1'b0, rsp_v: 1'b0, rsp_ok: 1'b0, have_prev: 1'b0,
        err: 1'b0, data: '0
    };

    seq_t q, d;

    always_comb begin
        d         = q;
        d.rsp_v   = 1'b0;
        req_ready = 1'b0;
        ld_acq    = 1'b0;
        ld_wake   = 1'b0;
        wd_run    = (q.st == S_RDO) || (q.st == S_INTW);

        case (q.st)
            S_IDLE: begin
                if (pd_req) begin
                    d.pd_n = 1'b0;
                    d.st   = S_SLEEP;
                end else if (gap_done) begin
                    req_ready = 1'b1;
                    if (req_valid) begin
                        d.mode = adc_mode_e'(cfg_mode);
                        d.err  = 1'b0;
                        d.cs_n = 1'b0;
                        d.cnt  = CW'(WR_CYC - 1);
                        case (adc_mode_e'(cfg_mode))
                            M_RDONLY: begin
                                d.rd_n = 1'b0;
                                d.seen = 1'b0;
                                d.st   = S_RDO;
                            end
                            M_PIPE: begin
                                d.wr_n = 1'b0;
                                d.rd_n = 1'b0;
                                d.st   = S_WRLO;
                            end
                            default: begin
                                d.wr_n = 1'b0;
                                d.st   = S_WRLO;
                            end
                        endcase
                    end
                end
            end

            S_SLEEP: begin
                if (!pd_req) begin
                    d.pd_n  = 1'b1;
                    d.st    = S_IDLE;
                    ld_wake = 1'b1;
                end
            end

            S_RDO: begin
                if (tmo) begin
                    d.cs_n = 1'b1;
                    d.rd_n = 1'b1;
                    d.err  = 1'b1;
                    d.st   = S_IDLE;
                    ld_acq = 1'b1;
                end else if (!adc_rdy) begin
                    d.seen = 1'b1;
                end else if (q.seen) begin
                    d.data      = adc_d;
                    d.rsp_v     = 1'b1;
                    d.rsp_ok    = 1'b1;
                    d.have_prev = 1'b1;
                    d.cs_n      = 1'b1;
                    d.rd_n      = 1'b1;
                    d.st        = S_IDLE;
                    ld_acq      = 1'b1;
                end
            end

            S_WRLO: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    d.wr_n = 1'b1;
                    case (q.mode)
                        M_PIPE: begin
                            d.rd_n   = 1'b1;
                            d.data   = adc_d;
                            d.rsp_v  = 1'b1;
                            d.rsp_ok = q.have_prev;
                            d.st     = S_INTW;
                        end
                        M_WR_EARLY: begin
                            d.cnt = CW'(RDLY_CYC - 1);
                            d.st  = S_WRGAP;
                        end
                        default: d.st = S_INTW;
                    endcase
                end
            end

            S_WRGAP: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    d.rd_n = 1'b0;
                    d.cnt  = CW'(ACC_CYC - 1);
                    d.st   = S_RDLO;
                end
            end

            S_INTW: begin
                if (tmo) begin
                    d.cs_n = 1'b1;
                    d.err  = 1'b1;
                    d.st   = S_IDLE;
                    ld_acq = 1'b1;
                end else if (!adc_int_n) begin
                    if (q.mode == M_PIPE) begin
                        d.cs_n      = 1'b1;
                        d.have_prev = 1'b1;
                        d.st        = S_IDLE;
                        ld_acq      = 1'b1;
                    end else begin
                        d.rd_n = 1'b0;
                        d.cnt  = CW'(ACC_CYC - 1);
                        d.st   = S_RDLO;
                    end
                end
            end

            S_RDLO: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    d.data      = adc_d;
                    d.rsp_v     = 1'b1;
                    d.rsp_ok    = 1'b1;
                    d.have_prev = 1'b1;
                    d.rd_n      = 1'b1;
                    d.cs_n      = 1'b1;
                    d.st        = S_IDLE;
                    ld_acq      = 1'b1;
                end
            end

            default: d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign cs_n      = q.cs_n;
    assign wr_n      = q.wr_n;
    assign rd_n      = q.rd_n;
    assign pd_n      = q.pd_n;
    assign cur_mode  = q.mode;
    assign mode_pin  = (q.mode != M_RDONLY);
    assign rsp_valid = q.rsp_v;
    assign rsp_data  = q.data;
    assign rsp_ok    = q.rsp_ok;
    assign err       = q.err;
endmodule

// File: rtl/adc_strobe_ctl.sv
module adc_strobe_ctl
    import adc_strobe_pkg::*;
#(
    parameter int DW        = 8,
    parameter int CLK_NS    = 10,
    parameter int T_WR_NS   = 250,
    parameter int T_RDLY_NS = 250,
    parameter int T_ACC_NS  = 160,
    parameter int T_ACQ_NS  = 160,
    parameter int T_WAKE_NS = 360,
    parameter int TMO_CYC   = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_mode,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          pd_req,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_ok,
    output logic          err_timeout,
    output logic          adc_cs_n,
    output logic          adc_wr_n,
    output logic          adc_rd_n,
    output logic          adc_mode,
    output logic          adc_pd_n,
    input  logic          adc_rdy,
    input  logic          adc_int_n,
    input  logic [DW-1:0] adc_d
);
    localparam int WR_CYC   = ns_to_cyc(T_WR_NS, CLK_NS);
    localparam int RDLY_CYC = ns_to_cyc(T_RDLY_NS, CLK_NS);
    localparam int ACC_CYC  = ns_to_cyc(T_ACC_NS, CLK_NS);
    localparam int ACQ_CYC  = ns_to_cyc(T_ACQ_NS, CLK_NS);
    localparam int WAKE_CYC = ns_to_cyc(T_WAKE_NS, CLK_NS);

    logic      gap_done, ld_acq, ld_wake, wd_run, tmo;
    adc_mode_e cur_mode;

    adc_gap_tmr #(.ACQ_CYC(ACQ_CYC), .WAKE_CYC(WAKE_CYC)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_acq  (ld_acq),
        .ld_wake (ld_wake),
        .done    (gap_done)
    );

    adc_wdog #(.TMO_CYC(TMO_CYC)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (wd_run),
        .expire (tmo)
    );

    adc_seq #(
        .DW(DW), .WR_CYC(WR_CYC), .RDLY_CYC(RDLY_CYC), .ACC_CYC(ACC_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_mode  (cfg_mode),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .pd_req    (pd_req),
        .gap_done  (gap_done),
        .tmo       (tmo),
        .ld_acq    (ld_acq),
        .ld_wake   (ld_wake),
        .wd_run    (wd_run),
        .adc_rdy   (adc_rdy),
        .adc_int_n (adc_int_n),
        .adc_d     (adc_d),
        .cs_n      (adc_cs_n),
        .wr_n      (adc_wr_n),
        .rd_n      (adc_rd_n),
        .pd_n      (adc_pd_n),
        .mode_pin  (adc_mode),
        .cur_mode  (cur_mode),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_ok    (rsp_ok),
        .err       (err_timeout)
    );
endmodule

// File: rtl/adc_strobe_chk.sv
module adc_strobe_chk #(
    parameter int WR_CYC   = 25,
    parameter int RDLY_CYC = 25,
    parameter int ACQ_CYC  = 16,
    parameter int WAKE_CYC = 36
) (
    input logic       clk,
    input logic       rst_n,
    input logic       adc_cs_n,
    input logic       adc_wr_n,
    input logic       adc_rd_n,
    input logic       adc_pd_n,
    input logic       adc_mode,
    input logic       adc_int_n,
    input logic       rsp_valid,
    input logic       err_timeout,
    input logic [1:0] cur_mode
);
    localparam int CW = $clog2(WR_CYC + RDLY_CYC + ACQ_CYC + WAKE_CYC + 4) + 1;
    localparam logic [CW-1:0] SAT = '1;

    logic [CW-1:0] wr_lo_q, wr_hi_q, cs_hi_q, pd_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_lo_q <= '0;
            wr_hi_q <= '0;
            cs_hi_q <= SAT;
            pd_hi_q <= SAT;
        end else begin
            wr_lo_q <= adc_wr_n ? '0 : ((wr_lo_q == SAT) ? SAT : wr_lo_q + 1'b1);
            wr_hi_q <= !adc_wr_n ? '0 : ((wr_hi_q == SAT) ? SAT : wr_hi_q + 1'b1);
            cs_hi_q <= !adc_cs_n ? '0 : ((cs_hi_q == SAT) ? SAT : cs_hi_q + 1'b1);
            pd_hi_q <= !adc_pd_n ? '0 : ((pd_hi_q == SAT) ? SAT : pd_hi_q + 1'b1);
        end
    end

    p_cs_hi_in_pd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_pd_n |-> adc_cs_n);

    p_wr_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_wr_n) |-> (wr_lo_q == CW'(WR_CYC)));

    p_early_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(adc_rd_n) && cur_mode == 2'd2) |-> (wr_hi_q == CW'(RDLY_CYC)));

    p_rd_after_eoc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(adc_rd_n) && cur_mode == 2'd1) |-> !adc_int_n);

    p_acq_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> (cs_hi_q >= CW'(ACQ_CYC)));

    p_wake_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> (pd_hi_q >= CW'(WAKE_CYC)));

    p_pipe_tied_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == 2'd3 && !adc_cs_n) |-> (adc_wr_n == adc_rd_n));

    p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n && !$past(adc_cs_n)) |-> $stable(adc_mode));

    p_tmo_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> adc_cs_n);

    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind adc_strobe_ctl adc_strobe_chk #(
    .WR_CYC(WR_CYC), .RDLY_CYC(RDLY_CYC), .ACQ_CYC(ACQ_CYC), .WAKE_CYC(WAKE_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_cs_n    (adc_cs_n),
    .adc_wr_n    (adc_wr_n),
    .adc_rd_n    (adc_rd_n),
    .adc_pd_n    (adc_pd_n),
    .adc_mode    (adc_mode),
    .adc_int_n   (adc_int_n),
    .rsp_valid   (rsp_valid),
    .err_timeout (err_timeout),
    .cur_mode    (cur_mode)
);

// File: tb/sim_adc_strobe_ctl.sv
module sim_adc_strobe_ctl;
    localparam int E_WR   = 5;   // ceil(45/10)
    localparam int E_RDLY = 4;   // ceil(31/10)
    localparam int E_ACQ  = 6;   // ceil(60/10)
    localparam int E_WAKE = 12;  // ceil(115/10)
    localparam int E_TMO  = 40;
    localparam int CONV   = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic       req_valid = 1'b0, pd_req = 1'b0;
    logic       req_ready, rsp_valid, rsp_ok, err_timeout;
    logic [7:0] rsp_data;
    logic       adc_cs_n, adc_wr_n, adc_rd_n, adc_mode, adc_pd_n;
    logic       adc_rdy, adc_int_n;
    logic [7:0] adc_d;

    adc_strobe_ctl #(
        .DW(8), .CLK_NS(10), .T_WR_NS(45), .T_RDLY_NS(31), .T_ACC_NS(30),
        .T_ACQ_NS(60), .T_WAKE_NS(115), .TMO_CYC(E_TMO)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .req_valid(req_valid),
        .req_ready(req_ready), .pd_req(pd_req), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_ok(rsp_ok), .err_timeout(err_timeout),
        .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n),
        .adc_mode(adc_mode), .adc_pd_n(adc_pd_n), .adc_rdy(adc_rdy),
        .adc_int_n(adc_int_n), .adc_d(adc_d)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // ---------------- converter model (acts on falling clock edges) ----------------
    logic [7:0] m_sample = 8'h00, m_result = 8'h00;
    logic m_rdy = 1'b1, m_int_n = 1'b1;
    bit   m_mute = 0;
    bit   pcs = 1, pwr = 1, prd = 1, busy = 0, counting = 0;
    int   ccnt = 0;
    assign adc_rdy   = m_rdy;
    assign adc_int_n = m_int_n;
    assign adc_d     = m_result;

    always @(negedge clk) begin
        bit fcs, rcs, fwr, rwr, frd, rrd, fin;
        fcs = pcs && !adc_cs_n;  rcs = !pcs && adc_cs_n;
        fwr = pwr && !adc_wr_n;  rwr = !pwr && adc_wr_n;
        frd = prd && !adc_rd_n;  rrd = !prd && adc_rd_n;
        fin = 0;
        if (rcs || rrd) m_int_n <= 1'b1;
        if (busy && counting) begin
            if (ccnt <= 1) fin = 1; else ccnt--;
        end
        if (!adc_mode) begin
            if (fcs && !m_mute) m_rdy <= 1'b0;
            if (frd && !adc_cs_n) begin busy = 1; counting = 1; ccnt = CONV; end
        end else begin
            if (frd && busy && counting) fin = 1;
            if (fwr) begin busy = 1; counting = 0; end
            if (rwr && busy && !counting) begin counting = 1; ccnt = CONV; end
        end
        if (fin) begin
            if (!m_mute) begin m_result <= m_sample; m_int_n <= 1'b0; end
            m_rdy <= 1'b1;
            busy = 0; counting = 0;
        end
        pcs = adc_cs_n; pwr = adc_wr_n; prd = adc_rd_n;
    end

    // ---------------- scoreboard ----------------
    typedef struct { logic [7:0] d; bit ok; bit chk_d; string tag; } exp_t;
    exp_t exp_q[$];
    int   cur_mode_b = 0;

    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R11 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rsp_ok == e.ok, {e.tag, " ok flag"}, rsp_ok, e.ok);
                if (e.chk_d) chk(rsp_data == e.d, {e.tag, " data"}, rsp_data, e.d);
            end
        end
    end

    // ---------------- protocol monitor ----------------
    bit mcs = 1, mwr = 1, mrd = 1, mpd = 1, pd_since = 0, pd_cs_bad = 0;
    int wlo = 0, whi = 0, chi = 1000, pdhi = 1000;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mwr && adc_wr_n) chk(wlo == E_WR, "R3 write pulse width", wlo, E_WR);
            if (mrd && !adc_rd_n && cur_mode_b == 2) chk(whi == E_RDLY, "R4 read delay", whi, E_RDLY);
            if (mrd && !adc_rd_n && cur_mode_b == 1) chk(!adc_int_n, "R3 read after end of conversion", adc_int_n, 0);
            if (mrd && !adc_rd_n && cur_mode_b == 0) chk(adc_wr_n && !adc_cs_n, "R2 read-only strobes", adc_wr_n, 1);
            if (cur_mode_b == 3 && (mwr != adc_wr_n || mrd != adc_rd_n))
                chk(adc_wr_n == adc_rd_n, "R5 tied strobes", adc_wr_n, adc_rd_n);
            if (mcs && !adc_cs_n) begin
                if (pd_since) chk(pdhi >= E_WAKE, "R8 wake gap", pdhi, E_WAKE);
                else          chk(chi >= E_ACQ, "R6 acquisition gap", chi, E_ACQ);
                pd_since = 0;
            end
            if (!mpd && adc_pd_n) begin
                chk(!pd_cs_bad, "R7 select high in power-down", pd_cs_bad, 0);
                pd_cs_bad = 0;
            end
            wlo  = adc_wr_n ? 0 : wlo + 1;
            whi  = adc_wr_n ? whi + 1 : 0;
            chi  = adc_cs_n ? chi + 1 : 0;
            if (!adc_pd_n) begin
                pd_since = 1; pdhi = 0;
                if (!adc_cs_n) pd_cs_bad = 1;
            end else begin
                pdhi++;
            end
        end
        mcs = adc_cs_n; mwr = adc_wr_n; mrd = adc_rd_n; mpd = adc_pd_n;
    end

    // ---------------- driver ----------------
    logic [7:0] last_s = 8'h00;
    bit         have = 0;

    task automatic issue(input int mode, input logic [7:0] s, input bit push);
        exp_t e;
        bit   mode_ok;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cfg_mode   = mode[1:0];
        m_sample   = s;
        cur_mode_b = mode;
        if (push) begin
            if (mode == 3) begin
                e.d = last_s; e.ok = have; e.chk_d = have; e.tag = "R5 pipelined";
            end else begin
                e.d = s; e.ok = 1;
                e.chk_d = 1;
                e.tag = (mode == 0) ? "R2 read-only" : (mode == 1) ? "R3 wait mode" : "R4 early read";
            end
            exp_q.push_back(e);
        end
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_mode  = ~mode[1:0];            // R10: must not disturb this conversion
        mode_ok   = 1;
        for (int i = 0; i < 300 && !adc_cs_n; i++) begin
            if (adc_mode != (mode != 0)) mode_ok = 0;
            @(negedge clk);
        end
        chk(mode_ok, "R10 mode pin held", mode_ok, 1);
        if (push) begin
            last_s = s;
            have   = 1;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(adc_cs_n && adc_wr_n && adc_rd_n, "R1 strobes high", {adc_cs_n, adc_wr_n, adc_rd_n}, 7);
        chk(adc_pd_n, "R1 powered", adc_pd_n, 1);
        chk(!adc_mode, "R1 mode pin", adc_mode, 0);
        chk(!rsp_valid && !err_timeout, "R1 outputs idle", {rsp_valid, err_timeout}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        issue(3, 8'hA5, 1);     // first pipelined: flagged not ok
        issue(3, 8'h3C, 1);
        issue(0, 8'h5A, 1);
        issue(0, 8'hFF, 1);
        issue(1, 8'h01, 1);
        issue(1, 8'h80, 1);
        issue(2, 8'h7E, 1);
        issue(2, 8'h00, 1);
        issue(3, 8'h11, 1);
        issue(3, 8'h22, 1);
        repeat (20) @(negedge clk);

        // R7 / R8 power-down and wake
        pd_req = 1'b1;
        repeat (15) @(negedge clk);
        chk(!adc_pd_n, "R7 power-down pin", adc_pd_n, 0);
        chk(adc_cs_n, "R7 select high", adc_cs_n, 1);
        chk(!req_ready, "R7 not ready", req_ready, 0);
        pd_req = 1'b0;
        issue(1, 8'h66, 1);

        // R9 timeout and recovery
        m_mute = 1;
        issue(1, 8'hC3, 0);
        chk(err_timeout, "R9 timeout flag", err_timeout, 1);
        chk(exp_q.size() == 0, "R9 no response", exp_q.size(), 0);
        m_mute = 0;
        issue(0, 8'h99, 1);
        chk(!err_timeout, "R9 flag cleared", err_timeout, 0);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all responses seen", exp_q.size(), 0);
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        report();
    end
endmodule